// File: doc/BRIEF.md
# Cascadable Registered Multiplier Slice

A signed 18 by 18 multiplier slice that returns the full 36-bit two's-complement product. Its first operand always enters on `a_i`. A build-time parameter sets where the second operand comes from: either the slice's own `b_i` port or a chain input `bcas_i` that a neighbouring slice drives. A chain output `bcas_o` carries exactly the value that reaches the multiplier's second input. Several slices can therefore be strung together so that they all multiply by one shared operand.

Three register stages are each set by a parameter: first operand, second operand and product. When a stage is enabled it has its own clock enable and its own synchronous clear, and all stages run on one clock. When a stage is disabled, that path is purely combinational. An active-low asynchronous reset clears every register that is present.

Top module: `mult_slice`

## Requirements
- R1: `p_o` is the full-precision signed product of the two signed 18-bit operands, sign-extended to 36 bits (for example, -131072 times -131072 gives +17179869184).
- R2: Parameter `B_SRC` picks the second operand. `BSRC_PORT` (0) uses `b_i` and ignores `bcas_i`. `BSRC_CHAIN` (1) uses `bcas_i` and ignores `b_i`.
- R3: With `B_REG`=1 the selected second operand is captured on the clock edge when `en_b_i` is high. With `B_REG`=0 it reaches the multiplier combinationally.
- R4: `bcas_o` always equals the multiplier's second operand. That is the register output when `B_REG`=1, and the selected raw input when `B_REG`=0.
- R5: `A_REG` and `P_REG` (each 0 or 1) insert or remove the first-operand and product registers. After the operands change, the product appears max(`A_REG`,`B_REG`)+`P_REG` clock edges later.
- R6: A present register whose enable is low, and whose clear is low, keeps its value.
- R7: `clr_a_i`, `clr_b_i` and `clr_p_i` are synchronous, take priority over the matching enable, and load zero. They have no effect on a stage that is not present.
- R8: While `rst_ni` is low, every present register reads zero.
- R9: A slice in chain mode fed from a neighbour's `bcas_o` multiplies by that neighbour's second operand, plus the delay of its own B register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 18 | First operand, signed |
| b_i | input | 18 | Second operand, port source |
| bcas_i | input | 18 | Second operand, chain source |
| en_a_i | input | 1 | First-operand register enable |
| en_b_i | input | 1 | Second-operand register enable |
| en_p_i | input | 1 | Product register enable |
| clr_a_i | input | 1 | First-operand register synchronous clear |
| clr_b_i | input | 1 | Second-operand register synchronous clear |
| clr_p_i | input | 1 | Product register synchronous clear |
| bcas_o | output | 18 | Second operand as seen by the multiplier |
| p_o | output | 36 | Signed product |

## Verification
The bench drives four slices at once, one per second-operand configuration, arranged as two chained pairs. Operand pairs cover both extremes (most negative times most negative, most positive times most negative), minus one, zero and mixed signs, so that sign extension and full precision are both exposed. A single step in the operands, sampled edge by edge, separates a fully registered slice from a combinational one and shows the latency count. Toggling the unused source input, dropping the enables and pulsing the clears then shows what each stage holds, ignores or zeroes.

// File: rtl/mslice_pkg.sv
package mslice_pkg;
  localparam int unsigned OP_W = 18;
  typedef enum logic {BSRC_PORT = 1'b0, BSRC_CHAIN = 1'b1} bsrc_e;
endpackage

// File: rtl/mslice_stage.sv
module mslice_stage #(
  parameter int unsigned W   = 18,
  parameter bit          USE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (USE) begin : g_reg
    logic [W-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q_q <= '0;
      else if (clr_i) q_q <= '0;
      else if (en_i)  q_q <= d_i;
    end
    assign q_o = q_q;

    // R7
    clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> q_o == '0);
    // R6
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !en_i) |=> $stable(q_o));
    // R3
    load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && en_i) |=> q_o == $past(d_i));
  end else begin : g_wire
    logic unused_ctl;
    assign unused_ctl = ^{clk_i, rst_ni, clr_i, en_i};
    assign q_o = d_i;
  end
endmodule

// File: rtl/mslice_bpath.sv
module mslice_bpath
  import mslice_pkg::*;
#(
  parameter int unsigned W     = OP_W,
  parameter bsrc_e       B_SRC = BSRC_PORT,
  parameter bit          B_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] port_i,
  input  logic [W-1:0] chain_i,
  output logic [W-1:0] b_o
);
  logic [W-1:0] sel;

  if (B_SRC == BSRC_CHAIN) begin : g_chain
    logic unused_port;
    assign unused_port = ^port_i;
    assign sel = chain_i;
  end else begin : g_port
    logic unused_chain;
    assign unused_chain = ^chain_i;
    assign sel = port_i;
  end

  mslice_stage #(.W(W), .USE(B_REG)) i_breg (
    .clk_i, .rst_ni, .clr_i, .en_i, .d_i(sel), .q_o(b_o)
  );
endmodule

// File: rtl/mslice_mul.sv
module mslice_mul #(
  parameter int unsigned AW = 18,
  parameter int unsigned BW = 18,
  localparam int unsigned PW = AW + BW
) (
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [PW-1:0] p_o
);
  logic signed [PW-1:0] prod;
  assign prod = $signed(a_i) * $signed(b_i);
  assign p_o  = prod;
endmodule

// File: rtl/mult_slice.sv
module mult_slice
  import mslice_pkg::*;
#(
  parameter int unsigned AW    = OP_W,
  parameter int unsigned BW    = OP_W,
  parameter bsrc_e       B_SRC = BSRC_PORT,
  parameter bit          A_REG = 1'b1,
  parameter bit          B_REG = 1'b1,
  parameter bit          P_REG = 1'b1,
  localparam int unsigned PW   = AW + BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  input  logic [BW-1:0] bcas_i,
  input  logic          en_a_i,
  input  logic          en_b_i,
  input  logic          en_p_i,
  input  logic          clr_a_i,
  input  logic          clr_b_i,
  input  logic          clr_p_i,
  output logic [BW-1:0] bcas_o,
  output logic [PW-1:0] p_o
);
  logic [AW-1:0] a_q;
  logic [BW-1:0] b_q;
  logic [PW-1:0] prod;

  mslice_stage #(.W(AW), .USE(A_REG)) i_areg (
    .clk_i, .rst_ni, .clr_i(clr_a_i), .en_i(en_a_i), .d_i(a_i), .q_o(a_q)
  );

  mslice_bpath #(.W(BW), .B_SRC(B_SRC), .B_REG(B_REG)) i_bpath (
    .clk_i, .rst_ni, .clr_i(clr_b_i), .en_i(en_b_i),
    .port_i(b_i), .chain_i(bcas_i), .b_o(b_q)
  );

  mslice_mul #(.AW(AW), .BW(BW)) i_mul (.a_i(a_q), .b_i(b_q), .p_o(prod));

  mslice_stage #(.W(PW), .USE(P_REG)) i_preg (
    .clk_i, .rst_ni, .clr_i(clr_p_i), .en_i(en_p_i), .d_i(prod), .q_o(p_o)
  );

  assign bcas_o = b_q;

  if (!B_REG && B_SRC == BSRC_PORT) begin : g_pass_chk
    // R4
    bcas_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bcas_o == b_i);
  end
endmodule

// File: tb/test_mult_slice.sv
module test_mult_slice;
  import mslice_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [17:0] a = '0, b = '0, bx = '0, cas_x = '0;
  logic en_a = 1'b1, en_b = 1'b1, en_p = 1'b1;
  logic clr_a = 1'b0, clr_b = 1'b0, clr_p = 1'b0;
  logic [17:0] c0, c1, c2, c3;
  logic [35:0] p0, p1, p2, p3;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // s0: port, all registered (head of chain A)
  mult_slice #(.B_SRC(BSRC_PORT), .A_REG(1), .B_REG(1), .P_REG(1)) i_mult_slice (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .bcas_i(cas_x),
    .en_a_i(en_a), .en_b_i(en_b), .en_p_i(en_p),
    .clr_a_i(clr_a), .clr_b_i(clr_b), .clr_p_i(clr_p), .bcas_o(c0), .p_o(p0));
  // s1: chain, registered B, fed by s0
  mult_slice #(.B_SRC(BSRC_CHAIN), .A_REG(1), .B_REG(1), .P_REG(1)) i_s1 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(bx), .bcas_i(c0),
    .en_a_i(en_a), .en_b_i(en_b), .en_p_i(en_p),
    .clr_a_i(clr_a), .clr_b_i(clr_b), .clr_p_i(clr_p), .bcas_o(c1), .p_o(p1));
  // s2: port, fully combinational (head of chain B)
  mult_slice #(.B_SRC(BSRC_PORT), .A_REG(0), .B_REG(0), .P_REG(0)) i_s2 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .bcas_i(cas_x),
    .en_a_i(en_a), .en_b_i(en_b), .en_p_i(en_p),
    .clr_a_i(clr_a), .clr_b_i(clr_b), .clr_p_i(clr_p), .bcas_o(c2), .p_o(p2));
  // s3: chain, combinational, fed by s2
  mult_slice #(.B_SRC(BSRC_CHAIN), .A_REG(0), .B_REG(0), .P_REG(0)) i_s3 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(bx), .bcas_i(c2),
    .en_a_i(en_a), .en_b_i(en_b), .en_p_i(en_p),
    .clr_a_i(clr_a), .clr_b_i(clr_b), .clr_p_i(clr_p), .bcas_o(c3), .p_o(p3));

  function automatic logic [35:0] ref_mul(input logic [17:0] x, input logic [17:0] y);
    logic signed [35:0] r;
    r = $signed(x) * $signed(y);
    return r;
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    a = 18'h1234; b = 18'h0777;
    cyc(2);
    chk("R8 p0", p0, '0);
    chk("R8 c0", {18'b0, c0}, '0);
    chk("R8 p1", p1, '0);
    chk("R2 s2 comb in reset", p2, ref_mul(a, b));
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_products;
    logic [17:0] va [6] = '{18'h20000, 18'h1FFFF, 18'h3FFFF, 18'h00000, 18'h00123, 18'h3FF00};
    logic [17:0] vb [6] = '{18'h20000, 18'h20000, 18'h3FFFF, 18'h15555, 18'h3FFF9, 18'h00300};
    for (int i = 0; i < 6; i++) begin
      a = va[i]; b = vb[i];
      cyc(4);
      chk("R1 s0", p0, ref_mul(a, b));
      chk("R9 s1", p1, ref_mul(a, b));
      chk("R1 s2", p2, ref_mul(a, b));
      chk("R9 s3", p3, ref_mul(a, b));
      chk("R4 c1", {18'b0, c1}, {18'b0, b});
      chk("R4 c3", {18'b0, c3}, {18'b0, b});
    end
  endtask

  task automatic t_latency;
    logic [35:0] oldp, newp;
    a = 18'h00010; b = 18'h00020;
    cyc(4);
    oldp = ref_mul(a, b);
    a = 18'h3FFFD; b = 18'h00101;
    newp = ref_mul(a, b);
    #1 chk("R5 s2 zero latency", p2, newp);
    cyc(1);
    chk("R5 s0 edge1 old", p0, oldp);
    chk("R3 c0 captured", {18'b0, c0}, {18'b0, b});
    cyc(1);
    chk("R5 s0 edge2 new", p0, newp);
    chk("R9 c1 one more edge", {18'b0, c1}, {18'b0, b});
  endtask

  task automatic t_ignore;
    logic [35:0] exp1, exp3;
    a = 18'h00055; b = 18'h3FF80;
    cyc(4);
    exp1 = p1; exp3 = p3;
    bx = 18'h2AAAA;
    cas_x = 18'h1C0DE;
    #1 chk("R2 s3 ignores b_i", p3, exp3);
    chk("R2 s2 ignores bcas_i", p2, ref_mul(a, b));
    cyc(3);
    chk("R2 s1 ignores b_i", p1, exp1);
    chk("R2 s0 ignores bcas_i", p0, ref_mul(a, b));
  endtask

  task automatic t_hold;
    logic [17:0] b_old;
    logic [35:0] p_old;
    b_old = b; p_old = p0;
    en_b = 1'b0; en_p = 1'b0;
    b = 18'h01111; a = 18'h00777;
    cyc(3);
    chk("R6 c0 held", {18'b0, c0}, {18'b0, b_old});
    chk("R6 p0 held", p0, p_old);
    chk("R3 c2 follows", {18'b0, c2}, {18'b0, b});
    en_b = 1'b1; en_p = 1'b1;
    cyc(3);
    chk("R6 resume", p0, ref_mul(a, b));
  endtask

  task automatic t_clear;
    a = 18'h00321; b = 18'h00456;
    cyc(4);
    clr_b = 1'b1;
    cyc(1);
    chk("R7 c0 cleared over enable", {18'b0, c0}, '0);
    chk("R7 c2 no stage", {18'b0, c2}, {18'b0, b});
    clr_b = 1'b0; clr_p = 1'b1;
    cyc(1);
    chk("R7 p0 cleared", p0, '0);
    chk("R7 p2 no stage", p2, ref_mul(a, b));
    clr_p = 1'b0; clr_a = 1'b1;
    cyc(2);
    chk("R7 a cleared gives zero", p0, '0);
    clr_a = 1'b0;
    cyc(3);
    chk("R7 recovery", p0, ref_mul(a, b));
  endtask

  initial begin
    t_reset();
    t_products();
    t_latency();
    t_ignore();
    t_hold();
    t_clear();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule